// File: doc/BRIEF.md
# Half-Bridge Gate Command Monitor

This block sits between a controller's logic-level gate commands and four gate drivers: the high and low switches of a half-bridge, a power-factor-correction switch and a filament-heater switch. It brings every command and control input into the local clock domain through a synchronizer. It then gates the commands, registers the results and presents them to the drivers.

Two protections act on the half-bridge pair only. The first is an over-current latch. When the comparator flag is seen while protection is enabled, the latch sets, both half-bridge gates go low and a fault output rises. The latch releases only once both half-bridge commands are low at the same time and the flag has dropped, or when protection is disabled, which happens when the supply leaves its operating state. The second is a cross-conduction interlock with no memory. While both half-bridge commands are high, both half-bridge gates are held low, and normal operation resumes as soon as the clash ends. A global driver enable keeps all four gates low, for example during supply start-up.

Top module: `hb_gate_monitor`

## Requirements
- R1: After reset, all four gate outputs and the fault output are 0.
- R2: While the driver enable is 0, all four gate outputs are 0, whatever the commands are.
- R3: With the enable at 1, no fault and no clash, each gate output equals its command, delayed by SYNC_STAGES+1 clock cycles (3 cycles with default parameters).
- R4: When the over-current flag is 1 and protection is enabled, the fault output becomes 1. In the same cycle both half-bridge gate outputs become 0.
- R5: The fault stays set while either half-bridge command is 1 or the flag is still 1.
- R6: With protection enabled, the fault clears once the high and low commands are both 0 and the flag is 0. The gates then follow their commands again.
- R7: While protection is disabled, the fault output is 0 and the flag has no effect on any gate. Disabling protection also clears a held fault.
- R8: While the high and low commands are both 1, both half-bridge gate outputs are 0. This does not latch: the gates follow their commands again once the clash ends, and the fault output stays 0.
- R9: The PFC and heater gate outputs depend only on their own commands and the driver enable. Neither the fault nor the interlock affects them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | 1 | High-side switch command |
| lo_cmd | input | 1 | Low-side switch command |
| pfc_cmd | input | 1 | PFC switch command |
| heat_cmd | input | 1 | Heater switch command |
| oc_flag | input | 1 | Over-current comparator flag, high means over threshold |
| drv_en | input | 1 | Driver enable; 0 holds all gates low |
| ocp_en | input | 1 | Protection enable, high in operating mode |
| hi_gate | output | 1 | Gated high-side command |
| lo_gate | output | 1 | Gated low-side command |
| pfc_gate | output | 1 | Gated PFC command |
| heat_gate | output | 1 | Gated heater command |
| oc_fault | output | 1 | Over-current fault held |

## Verification
The assertions look at the synchronized copies of the inputs. They therefore take for granted that each asynchronous level reaching the block is a clean level, and that once it settles it stays put long enough to pass through the synchronizer. The bench changes its inputs only at falling clock edges. It holds every input pattern for at least the full SYNC_STAGES+1 latency, so no pulse is shorter than the pipeline and no glitch can race between the half-bridge commands and the flag.

// File: rtl/hbgm_pkg.sv
package hbgm_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
        logic pfc;
        logic heat;
    } gate_vec_t;

    typedef struct packed {
        gate_vec_t cmd;
        logic      oc_flag;
        logic      drv_en;
        logic      ocp_en;
    } in_vec_t;

    localparam int GATE_W = $bits(gate_vec_t);
    localparam int IN_W   = $bits(in_vec_t);

    // true when both half-bridge switches are asked to conduct together
    function automatic logic hb_clash(input gate_vec_t c);
        return c.hi & c.lo;
    endfunction

    // apply enable and half-bridge blocking to a command vector
    function automatic gate_vec_t gate_apply(input gate_vec_t c,
                                             input logic en,
                                             input logic hb_block);
        gate_vec_t r;
        r.hi   = en & c.hi & ~hb_block;
        r.lo   = en & c.lo & ~hb_block;
        r.pfc  = en & c.pfc;
        r.heat = en & c.heat;
        return r;
    endfunction

endpackage

// File: rtl/hbgm_sync.sv
module hbgm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [W-1:0] chain [N];

    genvar s;
    generate
        for (s = 0; s < N; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[N-1];
endmodule

// File: rtl/hbgm_fault_latch.sv
module hbgm_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic ocp_en,
    input  logic oc_flag,
    input  logic hi_cmd,
    input  logic lo_cmd,
    output logic fault_next,
    output logic fault_q
);
    logic release_ok;

    assign release_ok = ~hi_cmd & ~lo_cmd & ~oc_flag;

    always_comb begin
        if (!ocp_en)          fault_next = 1'b0;
        else if (oc_flag)     fault_next = 1'b1;
        else if (release_ok)  fault_next = 1'b0;
        else                  fault_next = fault_q;
    end

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= fault_next;
    end

    // R4: flag seen with protection on sets the latch
    a_r4_fault_sets: assert property (@(posedge clk) disable iff (rst)
        (ocp_en && oc_flag) |=> fault_q);

    // R5: latch holds while a half-bridge command stays high
    a_r5_fault_holds: assert property (@(posedge clk) disable iff (rst)
        (fault_q && ocp_en && (hi_cmd || lo_cmd)) |=> fault_q);

    // R6: release when commands low and flag gone
    a_r6_fault_clears: assert property (@(posedge clk) disable iff (rst)
        (ocp_en && !hi_cmd && !lo_cmd && !oc_flag) |=> !fault_q);

    // R7: protection disabled keeps the latch clear
    a_r7_disabled_clear: assert property (@(posedge clk) disable iff (rst)
        (!ocp_en) |=> !fault_q);
endmodule

// File: rtl/hbgm_gate_stage.sv
module hbgm_gate_stage
    import hbgm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_vec_t cmd,
    input  logic      drv_en,
    input  logic      fault_block,
    output gate_vec_t gate_q
);
    logic      hb_block;
    gate_vec_t gate_d;

    assign hb_block = fault_block | hb_clash(cmd);
    assign gate_d   = gate_apply(cmd, drv_en, hb_block);

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= gate_d;
    end

    // R8: clashing commands never reach the half-bridge gates
    a_r8_interlock: assert property (@(posedge clk) disable iff (rst)
        (cmd.hi && cmd.lo) |=> (!gate_q.hi && !gate_q.lo));

    // R2: enable low silences every gate
    a_r2_enable_off: assert property (@(posedge clk) disable iff (rst)
        (!drv_en) |=> (gate_q == '0));

    // R9: auxiliary gates track their command under enable only
    a_r9_aux_pass: assert property (@(posedge clk) disable iff (rst)
        drv_en |=> (gate_q.pfc == $past(cmd.pfc) && gate_q.heat == $past(cmd.heat)));
endmodule

// File: rtl/hb_gate_monitor.sv
module hb_gate_monitor
    import hbgm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic pfc_cmd,
    input  logic heat_cmd,
    input  logic oc_flag,
    input  logic drv_en,
    input  logic ocp_en,
    output logic hi_gate,
    output logic lo_gate,
    output logic pfc_gate,
    output logic heat_gate,
    output logic oc_fault
);
    in_vec_t   raw_in;
    in_vec_t   sync_in;
    logic      fault_next;
    logic      fault_q;
    gate_vec_t gates;

    assign raw_in.cmd.hi   = hi_cmd;
    assign raw_in.cmd.lo   = lo_cmd;
    assign raw_in.cmd.pfc  = pfc_cmd;
    assign raw_in.cmd.heat = heat_cmd;
    assign raw_in.oc_flag  = oc_flag;
    assign raw_in.drv_en   = drv_en;
    assign raw_in.ocp_en   = ocp_en;

    hbgm_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    hbgm_fault_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .ocp_en     (sync_in.ocp_en),
        .oc_flag    (sync_in.oc_flag),
        .hi_cmd     (sync_in.cmd.hi),
        .lo_cmd     (sync_in.cmd.lo),
        .fault_next (fault_next),
        .fault_q    (fault_q)
    );

    hbgm_gate_stage u_gates (
        .clk         (clk),
        .rst         (rst),
        .cmd         (sync_in.cmd),
        .drv_en      (sync_in.drv_en),
        .fault_block (fault_next),
        .gate_q      (gates)
    );

    assign hi_gate   = gates.hi;
    assign lo_gate   = gates.lo;
    assign pfc_gate  = gates.pfc;
    assign heat_gate = gates.heat;
    assign oc_fault  = fault_q;

    // R4: a visible fault always coincides with blocked half-bridge gates
    a_r4_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        oc_fault |-> (!hi_gate && !lo_gate));

    // R8: the two half-bridge gates are never high together
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hi_gate && lo_gate));
endmodule

// File: tb/hb_gate_monitor_tb.sv
module hb_gate_monitor_tb;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst;
    logic hi_cmd, lo_cmd, pfc_cmd, heat_cmd, oc_flag, drv_en, ocp_en;
    logic hi_gate, lo_gate, pfc_gate, heat_gate, oc_fault;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hb_gate_monitor #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst(rst),
        .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .pfc_cmd(pfc_cmd), .heat_cmd(heat_cmd),
        .oc_flag(oc_flag), .drv_en(drv_en), .ocp_en(ocp_en),
        .hi_gate(hi_gate), .lo_gate(lo_gate), .pfc_gate(pfc_gate),
        .heat_gate(heat_gate), .oc_fault(oc_fault)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got hi/lo/pfc/heat/fault=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] outs();
        return {hi_gate, lo_gate, pfc_gate, heat_gate, oc_fault};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic h, input logic l, input logic p, input logic ht,
                         input logic f);
        hi_cmd = h; lo_cmd = l; pfc_cmd = p; heat_cmd = ht; oc_flag = f;
    endtask

    task automatic t_reset();
        rst = 1'b1; drv_en = 1'b1; ocp_en = 1'b1;
        drive(1, 0, 1, 1, 0);
        step(4);
        chk("R1 reset", outs(), 5'b00000);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0);
        step(LAT);
    endtask

    task automatic t_enable_off();
        drv_en = 1'b0;
        drive(1, 0, 1, 1, 0);
        step(LAT + 1);
        chk("R2 enable off", outs(), 5'b00000);
        drv_en = 1'b1;
        step(LAT);
        chk("R2 enable back", outs(), 5'b10110);
        drive(0, 0, 0, 0, 0);
        step(LAT);
    endtask

    task automatic t_pass();
        drive(0, 1, 1, 0, 0);
        step(LAT - 1);
        chk("R3 latency not yet", outs(), 5'b00000);
        step(1);
        chk("R3 low and pfc follow", outs(), 5'b01100);
        drive(1, 0, 0, 1, 0);
        step(LAT);
        chk("R3 high and heater follow", outs(), 5'b10010);
        drive(0, 0, 0, 0, 0);
        step(LAT);
        chk("R3 all low", outs(), 5'b00000);
    endtask

    task automatic t_fault();
        drive(1, 0, 1, 1, 0);
        step(LAT);
        oc_flag = 1'b1;
        step(LAT - 1);
        chk("R4 before flag arrives", outs(), 5'b10110);
        step(1);
        chk("R4 fault sets and blocks; R9 aux kept", outs(), 5'b00111);
        oc_flag = 1'b0;
        step(LAT + 2);
        chk("R5 hold while high cmd", outs(), 5'b00111);
        drive(0, 1, 1, 1, 0);
        step(LAT + 2);
        chk("R5 hold while low cmd", outs(), 5'b00111);
        drive(0, 0, 1, 1, 1);
        step(LAT + 2);
        chk("R5 hold while flag high", outs(), 5'b00111);
        oc_flag = 1'b0;
        step(LAT);
        chk("R6 released", outs(), 5'b00110);
        drive(1, 0, 0, 0, 0);
        step(LAT);
        chk("R6 gates follow again", outs(), 5'b10000);
        drive(0, 0, 0, 0, 0);
        step(LAT);
    endtask

    task automatic t_ocp_off();
        ocp_en = 1'b0;
        drive(1, 0, 0, 0, 1);
        step(LAT + 1);
        chk("R7 flag ignored", outs(), 5'b10000);
        oc_flag = 1'b0;
        ocp_en = 1'b1;
        step(LAT);
        oc_flag = 1'b1;
        step(LAT);
        chk("R7 fault set before disable", outs(), 5'b00001);
        oc_flag = 1'b0;
        ocp_en = 1'b0;
        step(LAT);
        chk("R7 disable clears fault", outs(), 5'b10000);
        ocp_en = 1'b1;
        drive(0, 0, 0, 0, 0);
        step(LAT);
    endtask

    task automatic t_interlock();
        drive(1, 1, 1, 0, 0);
        step(LAT);
        chk("R8 clash blocks; R9 pfc kept", outs(), 5'b00100);
        step(3);
        chk("R8 still blocked", outs(), 5'b00100);
        drive(0, 1, 1, 0, 0);
        step(LAT);
        chk("R8 no latch after clash", outs(), 5'b01100);
        drive(0, 0, 0, 0, 0);
        step(LAT);
    endtask

    initial begin
        #(20 * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        drive(0, 0, 0, 0, 0);
        drv_en = 1'b0; ocp_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_enable_off();
        t_fault();
        t_ocp_off();
        t_interlock();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule